// File: doc/BRIEF.md
# Fractional-Step Time-of-Day Counter

The block keeps wall-clock time as a seconds count, a decimal nanosecond count that wraps at one billion, and a binary sub-nanosecond fraction. On every enabled clock cycle it adds a programmable period to this time. The period has an integer nanosecond part and a 32-bit binary fraction of a nanosecond. When the fraction overflows, the carry adds one more nanosecond. This lets the counter follow clocks whose period is not a whole number of nanoseconds. A one-cycle tick marks every second boundary.

A running counter can be given a new time by a load strobe. Four snapshot banks each freeze the full time value on their own strobe. The banks serve software reads, a hardware servo, Ethernet receive stamps and Ethernet transmit stamps. All the pins are plain control and status pins. The strobes are single-cycle and are always accepted, so the block has no back-pressure and no handshake. A strobe that is high for several cycles acts again on each of those cycles.

Top module: `tod_counter`

## Requirements
- R1: The active step is held in registers that reset to an integer part of 4 ns and a fraction of 0. A cycle with `step_wr` high copies `step_int` and `step_frac` into them. The new step is first used on the following cycle.
- R2: `now_nsec` always stays in the range 0 to 999,999,999. On each enabled cycle, `now_frac` becomes (fraction + step fraction) modulo 2^32. The carry out of that 33-bit sum adds 1 ns to the nanosecond sum.
- R3: On each enabled cycle the block forms nanoseconds + integer step + carry. If this sum is at least 1,000,000,000, `now_sec` increments and `now_nsec` becomes the sum minus 1,000,000,000. Otherwise `now_nsec` becomes the sum.
- R4: `sec_tick` is high for exactly one cycle per rollover, in the same cycle as the incremented seconds value. It is low on every other cycle.
- R5: With an integer step of 0 and a fraction of 0x80000000, starting from a zero fraction, the nanoseconds advance by one on every second cycle.
- R6: A cycle with `load_stb` high loads `load_sec` and `load_nsec` and clears the fraction. The load takes priority over the increment and does not raise `sec_tick`. A `load_nsec` above 999,999,999 is stored as 999,999,999.
- R7: While `run_en` is low and no load occurs, the time holds its value and `sec_tick` stays low. Loads and snapshots still work.
- R8: A cycle with `snap_stb[i]` high stores the registered time of that cycle, before that cycle's increment. The value appears on the outputs from the next cycle. Bank 0 is software, bank 1 hardware, bank 2 Ethernet receive and bank 3 Ethernet transmit. Bank i sits at bits [i*W +: W] of each flattened output, where W is the field width. Strobes on the same cycle are all taken, even on a rollover cycle.
- R9: A bank whose strobe is low keeps its value. All banks reset to zero.
- R10: The seconds count wraps from 2^48-1 to 0 on a rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Advance enable |
| step_wr | input | 1 | Update the step registers |
| step_int | input | 8 | Integer ns per cycle to store |
| step_frac | input | 32 | Fractional ns per cycle to store |
| load_stb | input | 1 | Load a new time |
| load_sec | input | 48 | Seconds to load |
| load_nsec | input | 30 | Nanoseconds to load |
| snap_stb | input | 4 | Per-bank snapshot strobes |
| now_sec | output | 48 | Live seconds |
| now_nsec | output | 30 | Live nanoseconds |
| now_frac | output | 32 | Live sub-ns fraction |
| snap_sec | output | 192 | Snapshot seconds, four banks |
| snap_nsec | output | 120 | Snapshot nanoseconds, four banks |
| snap_frac | output | 128 | Snapshot fractions, four banks |
| sec_tick | output | 1 | One-cycle second-boundary pulse |

## Verification
The assertions check on every cycle that the nanoseconds stay below one billion and that the tick never lasts two cycles. They also check that a tick comes with exactly one added second, that a load clears the fraction without a tick, that a disabled counter holds, and that each bank copies the time exactly on its strobe and holds it otherwise. Only the bench scenarios can show the following. The arithmetic of the integer-plus-fraction step, including the alternating carry of a half-nanosecond fraction. Saturation of out-of-range loads. The seconds wrap at 2^48. Four simultaneous snapshots taken on a rollover cycle.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned NS_PER_SEC = 32'd1_000_000_000;

  typedef enum logic [1:0] {
    SNAP_SW = 2'd0,
    SNAP_HW = 2'd1,
    SNAP_RX = 2'd2,
    SNAP_TX = 2'd3
  } snap_idx_e;
endpackage

// File: rtl/tod_step_reg.sv
module tod_step_reg #(
  parameter int STEP_W   = 8,
  parameter int FRAC_W   = 32,
  parameter int STEP_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [STEP_W-1:0] int_in,
  input  logic [FRAC_W-1:0] frac_in,
  output logic [STEP_W-1:0] int_q,
  output logic [FRAC_W-1:0] frac_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q  <= STEP_W'(STEP_RST);
      frac_q <= '0;
    end else if (wr) begin
      int_q  <= int_in;
      frac_q <= frac_in;
    end
  end

  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(int_q) && $stable(frac_q))); // R1
endmodule

// File: rtl/tod_advance.sv
module tod_advance
  import tod_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int NSEC_W = 30,
  parameter int FRAC_W = 32,
  parameter int STEP_W = 8
) (
  input  logic [SEC_W-1:0]  sec,
  input  logic [NSEC_W-1:0] nsec,
  input  logic [FRAC_W-1:0] frac,
  input  logic [STEP_W-1:0] step_int,
  input  logic [FRAC_W-1:0] step_frac,
  output logic [SEC_W-1:0]  nx_sec,
  output logic [NSEC_W-1:0] nx_nsec,
  output logic [FRAC_W-1:0] nx_frac,
  output logic              rollover
);
  localparam int NSUM_W = NSEC_W + 1;
  localparam logic [NSUM_W-1:0] WRAP = NSUM_W'(NS_PER_SEC);

  logic [FRAC_W:0]   frac_sum;
  logic              ns_carry;
  logic [NSUM_W-1:0] ns_sum;

  always_comb begin
    frac_sum = {1'b0, frac} + {1'b0, step_frac};
    ns_carry = frac_sum[FRAC_W];
    nx_frac  = frac_sum[FRAC_W-1:0];
    ns_sum   = {1'b0, nsec} + NSUM_W'(step_int) + NSUM_W'(ns_carry);
    rollover = (ns_sum >= WRAP);
    if (rollover) begin
      nx_nsec = NSEC_W'(ns_sum - WRAP);
      nx_sec  = sec + SEC_W'(1);
    end else begin
      nx_nsec = ns_sum[NSEC_W-1:0];
      nx_sec  = sec;
    end
  end
endmodule

// File: rtl/tod_time_reg.sv
module tod_time_reg
  import tod_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int NSEC_W = 30,
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              load_stb,
  input  logic [SEC_W-1:0]  load_sec,
  input  logic [NSEC_W-1:0] load_nsec,
  input  logic [SEC_W-1:0]  nx_sec,
  input  logic [NSEC_W-1:0] nx_nsec,
  input  logic [FRAC_W-1:0] nx_frac,
  input  logic              rollover,
  output logic [SEC_W-1:0]  sec,
  output logic [NSEC_W-1:0] nsec,
  output logic [FRAC_W-1:0] frac,
  output logic              tick
);
  localparam logic [NSEC_W-1:0] NSEC_TOP = NSEC_W'(NS_PER_SEC - 1);

  logic [NSEC_W-1:0] load_nsec_sat;

  always_comb begin
    load_nsec_sat = (load_nsec > NSEC_TOP) ? NSEC_TOP : load_nsec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec  <= '0;
      nsec <= '0;
      frac <= '0;
      tick <= 1'b0;
    end else if (load_stb) begin
      sec  <= load_sec;
      nsec <= load_nsec_sat;
      frac <= '0;
      tick <= 1'b0;
    end else if (run_en) begin
      sec  <= nx_sec;
      nsec <= nx_nsec;
      frac <= nx_frac;
      tick <= rollover;
    end else begin
      tick <= 1'b0;
    end
  end

  AST_NSEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(nsec) < NS_PER_SEC)); // R2
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R4
  AST_TICK_ADDS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (sec == $past(sec) + SEC_W'(1))); // R3
  AST_LOAD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> (frac == '0 && !tick)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !load_stb) |=> ($stable(sec) && $stable(nsec) && $stable(frac) && !tick)); // R7
endmodule

// File: rtl/tod_snap_bank.sv
module tod_snap_bank #(
  parameter int SEC_W  = 48,
  parameter int NSEC_W = 30,
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [SEC_W-1:0]  sec,
  input  logic [NSEC_W-1:0] nsec,
  input  logic [FRAC_W-1:0] frac,
  output logic [SEC_W-1:0]  q_sec,
  output logic [NSEC_W-1:0] q_nsec,
  output logic [FRAC_W-1:0] q_frac
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_sec  <= '0;
      q_nsec <= '0;
      q_frac <= '0;
    end else if (stb) begin
      q_sec  <= sec;
      q_nsec <= nsec;
      q_frac <= frac;
    end
  end

  AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> (q_sec == $past(sec) && q_nsec == $past(nsec) && q_frac == $past(frac))); // R8
  AST_SNAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> ($stable(q_sec) && $stable(q_nsec) && $stable(q_frac))); // R9
endmodule

// File: rtl/tod_counter.sv
module tod_counter #(
  parameter int SEC_W    = 48,
  parameter int NSEC_W   = 30,
  parameter int FRAC_W   = 32,
  parameter int STEP_W   = 8,
  parameter int STEP_RST = 4,
  parameter int NUM_SNAP = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run_en,
  input  logic                       step_wr,
  input  logic [STEP_W-1:0]          step_int,
  input  logic [FRAC_W-1:0]          step_frac,
  input  logic                       load_stb,
  input  logic [SEC_W-1:0]           load_sec,
  input  logic [NSEC_W-1:0]          load_nsec,
  input  logic [NUM_SNAP-1:0]        snap_stb,
  output logic [SEC_W-1:0]           now_sec,
  output logic [NSEC_W-1:0]          now_nsec,
  output logic [FRAC_W-1:0]          now_frac,
  output logic [NUM_SNAP*SEC_W-1:0]  snap_sec,
  output logic [NUM_SNAP*NSEC_W-1:0] snap_nsec,
  output logic [NUM_SNAP*FRAC_W-1:0] snap_frac,
  output logic                       sec_tick
);
  logic [STEP_W-1:0] cur_int;
  logic [FRAC_W-1:0] cur_frac;
  logic [SEC_W-1:0]  nx_sec;
  logic [NSEC_W-1:0] nx_nsec;
  logic [FRAC_W-1:0] nx_frac;
  logic              rollover;

  tod_step_reg #(.STEP_W(STEP_W), .FRAC_W(FRAC_W), .STEP_RST(STEP_RST)) u_step (
    .clk(clk), .rst_n(rst_n), .wr(step_wr),
    .int_in(step_int), .frac_in(step_frac),
    .int_q(cur_int), .frac_q(cur_frac)
  );

  tod_advance #(.SEC_W(SEC_W), .NSEC_W(NSEC_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) u_adv (
    .sec(now_sec), .nsec(now_nsec), .frac(now_frac),
    .step_int(cur_int), .step_frac(cur_frac),
    .nx_sec(nx_sec), .nx_nsec(nx_nsec), .nx_frac(nx_frac), .rollover(rollover)
  );

  tod_time_reg #(.SEC_W(SEC_W), .NSEC_W(NSEC_W), .FRAC_W(FRAC_W)) u_time (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .load_stb(load_stb),
    .load_sec(load_sec), .load_nsec(load_nsec),
    .nx_sec(nx_sec), .nx_nsec(nx_nsec), .nx_frac(nx_frac), .rollover(rollover),
    .sec(now_sec), .nsec(now_nsec), .frac(now_frac), .tick(sec_tick)
  );

  for (genvar g = 0; g < NUM_SNAP; g++) begin : g_bank
    tod_snap_bank #(.SEC_W(SEC_W), .NSEC_W(NSEC_W), .FRAC_W(FRAC_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .stb(snap_stb[g]),
      .sec(now_sec), .nsec(now_nsec), .frac(now_frac),
      .q_sec(snap_sec[g*SEC_W +: SEC_W]),
      .q_nsec(snap_nsec[g*NSEC_W +: NSEC_W]),
      .q_frac(snap_frac[g*FRAC_W +: FRAC_W])
    );
  end
endmodule

// File: tb/test_tod_counter.sv
`timescale 1ns/1ps
module test_tod_counter;
  localparam int NB = 4;
  localparam int GIGA = 1000000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0, step_wr = 1'b0, load_stb = 1'b0;
  logic [7:0] step_int = '0;
  logic [31:0] step_frac = '0;
  logic [47:0] load_sec = '0;
  logic [29:0] load_nsec = '0;
  logic [NB-1:0] snap_stb = '0;
  logic [47:0] now_sec;
  logic [29:0] now_nsec;
  logic [31:0] now_frac;
  logic [NB*48-1:0] snap_sec;
  logic [NB*30-1:0] snap_nsec;
  logic [NB*32-1:0] snap_frac;
  logic sec_tick;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [47:0] m_sec; logic [29:0] m_nsec; logic [31:0] m_frac; logic m_tick;
  logic [7:0] m_si; logic [31:0] m_sf;
  logic [47:0] m_ssec [NB]; logic [29:0] m_snsec [NB]; logic [31:0] m_sfrac [NB];

  always #10 clk = ~clk;

  tod_counter i_tod_counter (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .step_wr(step_wr),
    .step_int(step_int), .step_frac(step_frac), .load_stb(load_stb),
    .load_sec(load_sec), .load_nsec(load_nsec), .snap_stb(snap_stb),
    .now_sec(now_sec), .now_nsec(now_nsec), .now_frac(now_frac),
    .snap_sec(snap_sec), .snap_nsec(snap_nsec), .snap_frac(snap_frac),
    .sec_tick(sec_tick)
  );

  task automatic model_reset();
    m_sec = '0; m_nsec = '0; m_frac = '0; m_tick = 0; m_si = 8'd4; m_sf = '0;
    for (int i = 0; i < NB; i++) begin
      m_ssec[i] = '0; m_snsec[i] = '0; m_sfrac[i] = '0;
    end
  endtask

  function automatic logic [29:0] sat_ns(logic [29:0] v);
    return (32'(v) > GIGA - 1) ? 30'(GIGA - 1) : v;
  endfunction

  task automatic model_step();
    logic [32:0] fs; longint ns;
    for (int i = 0; i < NB; i++)
      if (snap_stb[i]) begin
        m_ssec[i] = m_sec; m_snsec[i] = m_nsec; m_sfrac[i] = m_frac;
      end
    m_tick = 0;
    if (load_stb) begin
      m_sec = load_sec; m_nsec = sat_ns(load_nsec); m_frac = '0;
    end else if (run_en) begin
      fs = {1'b0, m_frac} + {1'b0, m_sf};
      ns = longint'(m_nsec) + longint'(m_si) + longint'(fs[32]);
      m_frac = fs[31:0];
      if (ns >= GIGA) begin
        m_sec = m_sec + 48'd1; ns = ns - GIGA; m_tick = 1;
      end
      m_nsec = 30'(ns);
    end
    if (step_wr) begin m_si = step_int; m_sf = step_frac; end
  endtask

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, "sec", longint'(now_sec), longint'(m_sec));
    chk(req, "nsec", longint'(now_nsec), longint'(m_nsec));
    chk(req, "frac", longint'(now_frac), longint'(m_frac));
    chk(req, "tick", longint'(sec_tick), longint'(m_tick));
    for (int i = 0; i < NB; i++) begin
      chk(req, "snap_sec", longint'(snap_sec[i*48 +: 48]), longint'(m_ssec[i]));
      chk(req, "snap_nsec", longint'(snap_nsec[i*30 +: 30]), longint'(m_snsec[i]));
      chk(req, "snap_frac", longint'(snap_frac[i*32 +: 32]), longint'(m_sfrac[i]));
    end
  endtask

  task automatic cyc(string req);
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    chk_all(req);
    step_wr = 0; load_stb = 0; snap_stb = '0;
  endtask

  task automatic do_load(logic [47:0] s, logic [29:0] n, string req);
    load_stb = 1; load_sec = s; load_nsec = n; cyc(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int ns0;
    seed = 32'd20240611;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    chk_all("R9 reset");
    rst_n = 1;
    // R1 default step of 4 ns
    run_en = 1;
    repeat (5) cyc("R1 default step");
    chk("R1", "nsec after 5", longint'(now_nsec), 20);

    // R6 load with priority over increment, saturation
    do_load(48'd77, 30'd500, "R6 load");
    chk("R6", "loaded nsec", longint'(now_nsec), 500);
    do_load(48'd5, 30'h3FFF_FFFF, "R6 saturate");
    chk("R6", "sat nsec", longint'(now_nsec), GIGA - 1);
    chk("R6", "no tick on load", longint'(sec_tick), 0);

    // R3 R4 rollover from near end
    do_load(48'd10, 30'(GIGA - 6), "R3 preload");
    cyc("R3 before wrap");
    cyc("R3 wrap");
    chk("R3", "sec wrap", longint'(now_sec), 11);
    chk("R3", "nsec wrap", longint'(now_nsec), 2);
    chk("R4", "tick high", longint'(sec_tick), 1);
    cyc("R4 tick low next");
    chk("R4", "tick low", longint'(sec_tick), 0);

    // R10 seconds wrap at 2^48
    do_load(48'hFFFF_FFFF_FFFF, 30'(GIGA - 1), "R10 preload");
    cyc("R10 wrap");
    chk("R10", "sec zero", longint'(now_sec), 0);

    // R5 half-ns fraction
    step_wr = 1; step_int = 8'd0; step_frac = 32'h8000_0000; cyc("R5 set step");
    do_load(48'd1, 30'd0, "R5 load");
    for (int k = 1; k <= 8; k++) begin
      cyc("R5 half step");
      chk("R5", "half-ns count", longint'(now_nsec), k / 2);
    end

    // R8 all banks on a rollover cycle
    step_wr = 1; step_int = 8'd7; step_frac = 32'h1234_5678; cyc("R1 new step");
    do_load(48'd200, 30'(GIGA - 3), "R8 preload");
    snap_stb = 4'hF; cyc("R8 simultaneous");
    for (int i = 0; i < NB; i++)
      chk("R8", "bank pre-increment nsec", longint'(snap_nsec[i*30 +: 30]), GIGA - 3);
    chk("R8", "live after wrap sec", longint'(now_sec), 201);

    // R7 disabled holds, loads and snaps still work
    run_en = 0;
    ns0 = int'(now_nsec);
    repeat (4) cyc("R7 hold");
    chk("R7", "held nsec", longint'(now_nsec), longint'(ns0));
    snap_stb = 4'b0100; cyc("R7 snap while idle");
    do_load(48'd9, 30'd9, "R7 load while idle");
    cyc("R7 idle after load");
    chk("R7", "idle load nsec", longint'(now_nsec), 9);
    run_en = 1;

    // R2 R3 R8 R9 constrained random
    for (int n = 0; n < 4000; n++) begin
      run_en = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 99) < 3) begin
        load_stb = 1;
        load_sec = {$urandom(), $urandom()};
        if ($urandom_range(0, 3) == 0) load_nsec = 30'($urandom());
        else load_nsec = 30'(GIGA - 1 - $urandom_range(0, 3000));
      end
      if ($urandom_range(0, 99) < 2) begin
        step_wr = 1; step_int = 8'($urandom()); step_frac = $urandom();
      end
      for (int i = 0; i < NB; i++) snap_stb[i] = ($urandom_range(0, 9) == 0);
      cyc("R2 R3 R8 R9 random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule